// File: doc/BRIEF.md
# DMA Page Register File

This block holds the upper address bytes for the four channels of one DMA controller. There is one byte-wide page register per channel. A second bank can be built in to give each channel a byte-wide high-page register as well. Software reaches either bank through an eight-offset I/O window. The three offset bits pick a channel through a fixed, sparse table, and offsets outside that table lead nowhere.

For every channel the block combines its page bytes with the channel's current 16-bit address into a 31-bit physical address, and presents that address continuously. It also presents the address of the byte at a given transfer position. This address counts upward from the physical address, or downward when the direction bit of the channel's mode byte is set. Reads answer one cycle after the strobe, with a valid flag.

Top module: `dma_page_regfile`

## Requirements
- R1: After reset every page and high-page register reads as zero, and every channel's physical address equals its current address.
- R2: Offsets map to channels as follows: 1 selects channel 2, 2 selects channel 3, 3 selects channel 1, and 7 selects channel 0. A byte write through a mapped offset updates only that channel's register in the selected bank (`bank_sel` 0 = page, 1 = high page).
- R3: A write through offset 0, 4, 5 or 6 changes no register in either bank.
- R4: A read through offset 0, 4, 5 or 6 returns zero.
- R5: A read returns the full 8-bit register value. `rd_valid` is high, and `rd_data` holds the result, in the cycle after the one where `rd_en` was sampled.
- R6: The physical address of channel c has high-page bits 6..0 at bits 30..24, the page byte at bits 23..16 and the current address at bits 15..0. High-page bit 7 is not used in it.
- R7: With `HIGH_EN` = 0 the high bank does not respond: writes to it change nothing, reads from it return zero, and bits 30..24 of every physical address are zero.
- R8: Only accesses with `acc_bytes` = 1 take effect. For any other size a write is ignored and a read returns zero, with `rd_valid` still raised.
- R9: When bit 5 of a channel's mode byte is clear, its transfer address is the physical address plus the position. When bit 5 is set, it is the physical address minus the position minus one. Both results wrap modulo 2^31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| bank_sel | input | 1 | 0 = page bank, 1 = high-page bank |
| port_off | input | 3 | Offset inside the window |
| acc_bytes | input | 3 | Access size in bytes; only 1 is accepted |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, registered |
| rd_valid | output | 1 | Read result valid |
| cur_addr | input | 64 | Current 16-bit address per channel, channel 0 in the low bits |
| chan_pos | input | 64 | Transfer position per channel |
| chan_mode | input | 32 | Mode byte per channel |
| phys_addr | output | 124 | 31-bit physical address per channel |
| xfer_addr | output | 124 | 31-bit transfer byte address per channel |

## Verification
The bench builds two copies side by side from the same stimulus, one with `HIGH_EN` = 1 and one with `HIGH_EN` = 0. This lets every high-bank access be checked once as a live register and once as an absent one. The enabled copy covers the sparse offset table, high-page bit 7 being dropped from the address, and the wrap of a downward transfer below address zero. The disabled copy shows that bits 30..24 stay zero whatever is written.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
    localparam int NUM_CH   = 4;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int OFF_W    = 3;
    localparam int BYTE_W   = 8;
    localparam int SIZE_W   = 3;
    localparam int DIR_BIT  = 5;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } chan_sel_t;

    // Sparse offset-to-channel table
    function automatic chan_sel_t offset_to_chan(input logic [OFF_W-1:0] off);
        chan_sel_t s;
        s = '0;
        case (off)
            3'd1: begin s.hit = 1'b1; s.ch = CH_W'(2); end
            3'd2: begin s.hit = 1'b1; s.ch = CH_W'(3); end
            3'd3: begin s.hit = 1'b1; s.ch = CH_W'(1); end
            3'd7: begin s.hit = 1'b1; s.ch = CH_W'(0); end
            default: s = '0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/dma_page_decode.sv
module dma_page_decode
    import dma_page_pkg::*;
(
    input  logic [OFF_W-1:0]  port_off,
    input  logic [SIZE_W-1:0] acc_bytes,
    output chan_sel_t         sel,
    output logic              size_ok
);
    always_comb begin
        sel     = offset_to_chan(port_off);
        size_ok = (acc_bytes == SIZE_W'(1));
    end
endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank
    import dma_page_pkg::*;
#(
    parameter int PRESENT = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [CH_W-1:0]          rd_ch,
    output logic [NUM_CH*BYTE_W-1:0] regs_flat,
    output logic [BYTE_W-1:0]        rd_val
);
    typedef struct packed {
        logic [NUM_CH-1:0][BYTE_W-1:0] r;
    } bank_t;

    generate
        if (PRESENT != 0) begin : g_live
            bank_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (wr_en) st_d.r[wr_ch] = wr_data;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign regs_flat = st_q.r;
            assign rd_val    = st_q.r[rd_ch];

            // R2
            bank_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> regs_flat[wr_ch_past_q*BYTE_W +: BYTE_W] == wr_data_past_q);

            logic [CH_W-1:0]   wr_ch_past_q;
            logic [BYTE_W-1:0] wr_data_past_q;
            always_ff @(posedge clk) begin
                wr_ch_past_q   <= wr_ch;
                wr_data_past_q <= wr_data;
            end
        end else begin : g_absent
            logic absent_unused;
            assign absent_unused = ^{clk, rst_n, wr_en, wr_ch, wr_data, rd_ch};
            assign regs_flat = '0;
            assign rd_val    = '0;
        end
    endgenerate
endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr
    import dma_page_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HP_W   = 7,
    parameter int PG_W   = 8,
    localparam int PHYS_W = HP_W + PG_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HP_W-1:0]   hpage,
    input  logic [PG_W-1:0]   page,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] pos,
    input  logic              down,
    output logic [PHYS_W-1:0] phys,
    output logic [PHYS_W-1:0] xfer
);
    logic [PHYS_W-1:0] pos_ext;

    always_comb begin
        phys    = {hpage, page, cur};
        pos_ext = PHYS_W'(pos);
        if (down) xfer = phys - pos_ext - PHYS_W'(1);
        else      xfer = phys + pos_ext;
    end

    // R9
    up_zero_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!down && pos == '0) |-> xfer == {hpage, page, cur});

    // R9
    down_neighbour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (down && pos == '0) |-> (xfer + PHYS_W'(1)) == phys);
endmodule

// File: rtl/dma_page_regfile.sv
module dma_page_regfile
    import dma_page_pkg::*;
#(
    parameter int HIGH_EN = 1,
    parameter int ADDR_W  = 16,
    parameter int HP_W    = 7,
    localparam int PHYS_W = HP_W + BYTE_W + ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic                     bank_sel,
    input  logic [OFF_W-1:0]         port_off,
    input  logic [SIZE_W-1:0]        acc_bytes,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [BYTE_W-1:0]        rd_data,
    output logic                     rd_valid,
    input  logic [NUM_CH*ADDR_W-1:0] cur_addr,
    input  logic [NUM_CH*ADDR_W-1:0] chan_pos,
    input  logic [NUM_CH*BYTE_W-1:0] chan_mode,
    output logic [NUM_CH*PHYS_W-1:0] phys_addr,
    output logic [NUM_CH*PHYS_W-1:0] xfer_addr
);
    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rd_t;

    chan_sel_t                sel;
    logic                     size_ok;
    logic                     pg_wr, hp_wr;
    logic [NUM_CH*BYTE_W-1:0] pg_flat, hp_flat;
    logic [BYTE_W-1:0]        pg_rd, hp_rd;
    rd_t                      rd_d, rd_q;

    dma_page_decode u_dec (
        .port_off (port_off),
        .acc_bytes(acc_bytes),
        .sel      (sel),
        .size_ok  (size_ok)
    );

    assign pg_wr = wr_en && size_ok && sel.hit && !bank_sel;
    assign hp_wr = wr_en && size_ok && sel.hit &&  bank_sel;

    dma_page_bank #(.PRESENT(1)) u_pg (
        .clk(clk), .rst_n(rst_n), .wr_en(pg_wr), .wr_ch(sel.ch),
        .wr_data(wr_data), .rd_ch(sel.ch), .regs_flat(pg_flat), .rd_val(pg_rd)
    );

    dma_page_bank #(.PRESENT(HIGH_EN)) u_hp (
        .clk(clk), .rst_n(rst_n), .wr_en(hp_wr), .wr_ch(sel.ch),
        .wr_data(wr_data), .rd_ch(sel.ch), .regs_flat(hp_flat), .rd_val(hp_rd)
    );

    always_comb begin
        rd_d       = '0;
        rd_d.valid = rd_en;
        if (rd_en && size_ok && sel.hit)
            rd_d.data = bank_sel ? hp_rd : pg_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data  = rd_q.data;
    assign rd_valid = rd_q.valid;

    logic [NUM_CH-1:0] hp_top_unused;
    logic              mode_unused;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign hp_top_unused[c] = hp_flat[c*BYTE_W + BYTE_W - 1];
            dma_page_addr #(.ADDR_W(ADDR_W), .HP_W(HP_W), .PG_W(BYTE_W)) u_addr (
                .clk  (clk),
                .rst_n(rst_n),
                .hpage(hp_flat[c*BYTE_W +: HP_W]),
                .page (pg_flat[c*BYTE_W +: BYTE_W]),
                .cur  (cur_addr[c*ADDR_W +: ADDR_W]),
                .pos  (chan_pos[c*ADDR_W +: ADDR_W]),
                .down (chan_mode[c*BYTE_W + DIR_BIT]),
                .phys (phys_addr[c*PHYS_W +: PHYS_W]),
                .xfer (xfer_addr[c*PHYS_W +: PHYS_W])
            );
        end
    endgenerate

    assign mode_unused = ^{chan_mode, hp_top_unused};

    // R3
    unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !offset_to_chan(port_off).hit) |=> ($stable(pg_flat) && $stable(hp_flat)));

    // R5
    read_answer_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R8
    odd_size_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_bytes != SIZE_W'(1)) |=> rd_data == '0);

    // R8
    odd_size_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_bytes != SIZE_W'(1)) |=> ($stable(pg_flat) && $stable(hp_flat)));
endmodule

// File: tb/test_dma_page_regfile.sv
module test_dma_page_regfile;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int PW  = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic           wr_en = 0, rd_en = 0, bank_sel = 0;
    logic [2:0]     port_off = 0, acc_bytes = 3'd1;
    logic [7:0]     wr_data = 0;
    logic [NCH*AW-1:0] cur_addr = 0, chan_pos = 0;
    logic [NCH*8-1:0]  chan_mode = 0;
    logic [7:0]     rd_a, rd_b;
    logic           rv_a, rv_b;
    logic [NCH*PW-1:0] ph_a, xf_a, ph_b, xf_b;

    dma_page_regfile #(.HIGH_EN(1)) i_dma_page_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .bank_sel(bank_sel),
        .port_off(port_off), .acc_bytes(acc_bytes), .wr_data(wr_data),
        .rd_data(rd_a), .rd_valid(rv_a), .cur_addr(cur_addr), .chan_pos(chan_pos),
        .chan_mode(chan_mode), .phys_addr(ph_a), .xfer_addr(xf_a));

    dma_page_regfile #(.HIGH_EN(0)) i_dma_page_regfile_nohigh (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .bank_sel(bank_sel),
        .port_off(port_off), .acc_bytes(acc_bytes), .wr_data(wr_data),
        .rd_data(rd_b), .rd_valid(rv_b), .cur_addr(cur_addr), .chan_pos(chan_pos),
        .chan_mode(chan_mode), .phys_addr(ph_b), .xfer_addr(xf_b));

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_pg [NCH];
    logic [7:0] m_hp [NCH];

    typedef struct { logic [7:0] exp_a; logic [7:0] exp_b; string req; } rd_item_t;
    rd_item_t exp_q[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // offset table from R2; -1 = unmapped
    function automatic int chan_of(input logic [2:0] off);
        case (off)
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 1;
            3'd7: return 0;
            default: return -1;
        endcase
    endfunction

    function automatic logic [30:0] exp_phys(input int c, input bit hi);
        return {hi ? m_hp[c][6:0] : 7'd0, m_pg[c], cur_addr[c*AW +: AW]};
    endfunction

    task automatic wr(input bit bank, input logic [2:0] off, input logic [2:0] sz, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; bank_sel = bank; port_off = off; acc_bytes = sz; wr_data = d;
        @(negedge clk);
        wr_en = 0; acc_bytes = 3'd1;
        if (sz == 3'd1 && chan_of(off) >= 0) begin
            if (bank) m_hp[chan_of(off)] = d;
            else      m_pg[chan_of(off)] = d;
        end
    endtask

    task automatic rd(input bit bank, input logic [2:0] off, input logic [2:0] sz, input string req);
        rd_item_t it;
        int c;
        c = chan_of(off);
        it.req = req;
        it.exp_a = 0; it.exp_b = 0;
        if (sz == 3'd1 && c >= 0) begin
            it.exp_a = bank ? m_hp[c] : m_pg[c];
            it.exp_b = bank ? 8'd0 : m_pg[c];
        end
        @(negedge clk);
        rd_en = 1; bank_sel = bank; port_off = off; acc_bytes = sz;
        exp_q.push_back(it);
        @(negedge clk);
        rd_en = 0; acc_bytes = 3'd1;
    endtask

    // monitor: pop and compare when the design answers
    always @(negedge clk) begin
        if (rst_n && (rv_a || rv_b)) begin
            rd_item_t it;
            check("R5 valid pair", {31'd0, rv_b}, {31'd0, rv_a});
            if (exp_q.size() == 0) begin
                check("R5 unexpected read answer", 32'd1, 32'd0);
            end else begin
                it = exp_q.pop_front();
                check({it.req, " high-enabled"}, {24'd0, rd_a}, {24'd0, it.exp_a});
                check({it.req, " high-disabled"}, {24'd0, rd_b}, {24'd0, it.exp_b});
            end
        end
    end

    task automatic check_addrs(input string req);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            check({req, " phys hi-en"}, {1'b0, ph_a[c*PW +: PW]}, {1'b0, exp_phys(c, 1)});
            check({req, " phys hi-dis (R7)"}, {1'b0, ph_b[c*PW +: PW]}, {1'b0, exp_phys(c, 0)});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin m_pg[c] = 0; m_hp[c] = 0; end
        for (int c = 0; c < NCH; c++) cur_addr[c*AW +: AW] = 16'h1000 * (c + 1) + 16'h00A5;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check_addrs("R1");
        for (int o = 0; o < 8; o++) begin
            rd(0, 3'(o), 3'd1, "R1 page reset");
            rd(1, 3'(o), 3'd1, "R1 high reset");
        end

        // R2 / R6 page writes through each mapped offset
        wr(0, 3'd1, 3'd1, 8'h22);
        check_addrs("R2 off1");
        wr(0, 3'd2, 3'd1, 8'h33);
        wr(0, 3'd3, 3'd1, 8'h11);
        wr(0, 3'd7, 3'd1, 8'hF0);
        check_addrs("R2 R6 page");

        // high bank incl. bit 7 set (R6), disabled copy (R7)
        wr(1, 3'd7, 3'd1, 8'hC5);
        wr(1, 3'd3, 3'd1, 8'h7F);
        wr(1, 3'd1, 3'd1, 8'h80);
        wr(1, 3'd2, 3'd1, 8'h01);
        check_addrs("R6 R7 high");

        // R5 readback
        for (int o = 1; o < 8; o++) begin
            if (chan_of(3'(o)) >= 0) begin
                rd(0, 3'(o), 3'd1, "R5 page readback");
                rd(1, 3'(o), 3'd1, "R5 high readback (R7)");
            end
        end

        // R3 unmapped writes, R4 unmapped reads
        foreach (m_pg[i]) begin end
        wr(0, 3'd0, 3'd1, 8'hAA);
        wr(0, 3'd4, 3'd1, 8'hAB);
        wr(1, 3'd5, 3'd1, 8'hAC);
        wr(1, 3'd6, 3'd1, 8'hAD);
        check_addrs("R3 unmapped write");
        rd(0, 3'd0, 3'd1, "R4 unmapped read");
        rd(0, 3'd4, 3'd1, "R4 unmapped read");
        rd(1, 3'd5, 3'd1, "R4 unmapped read");
        rd(1, 3'd6, 3'd1, "R4 unmapped read");

        // R8 other sizes
        wr(0, 3'd7, 3'd2, 8'h5A);
        wr(1, 3'd1, 3'd4, 8'h5B);
        wr(0, 3'd2, 3'd0, 8'h5C);
        check_addrs("R8 size write");
        rd(0, 3'd7, 3'd2, "R8 size read");
        rd(1, 3'd3, 3'd4, "R8 size read");
        rd(0, 3'd1, 3'd1, "R8 page kept");

        // R9 direction
        chan_pos[0*AW +: AW] = 16'h0010;
        chan_pos[1*AW +: AW] = 16'h0010;
        chan_mode[1*8 + 5] = 1'b1;
        chan_mode[0*8 + 6] = 1'b1;   // non-direction bit, no effect
        @(negedge clk);
        check("R9 up ch0", {1'b0, xf_a[0*PW +: PW]}, {1'b0, exp_phys(0, 1) + 31'h10});
        check("R9 down ch1", {1'b0, xf_a[1*PW +: PW]}, {1'b0, exp_phys(1, 1) - 31'h11});
        // wrap below zero: clear channel 2 page/high, address 0
        wr(0, 3'd1, 3'd1, 8'h00);
        wr(1, 3'd1, 3'd1, 8'h00);
        cur_addr[2*AW +: AW] = 16'h0000;
        chan_pos[2*AW +: AW] = 16'h0000;
        chan_mode[2*8 + 5] = 1'b1;
        @(negedge clk);
        check("R9 down wrap", {1'b0, xf_a[2*PW +: PW]}, 32'h7FFF_FFFF);
        chan_pos[2*AW +: AW] = 16'hFFFF;
        chan_mode[2*8 + 5] = 1'b0;
        @(negedge clk);
        check("R9 up max pos", {1'b0, xf_a[2*PW +: PW]}, 32'h0000_FFFF);

        repeat (4) @(negedge clk);
        check("R5 queue drained", exp_q.size(), 0);
        finish_run();
    end
endmodule